// File: doc/BRIEF.md
# Shift-Add Constant Multiplier Sequencer

This block multiplies a 32-bit integer by one of a small set of fixed constants without a hardware multiplier. Each constant has its own short micro-program of shift-and-add steps. The steps run one per clock over a four-entry file of working values. A step writes one entry with one of three results: a scaled sum (1, 2, 4 or 8 times a first source plus a second source), the difference of two sources, or a first source shifted left by a fixed amount. Temporaries written by early steps stay in the file and later steps may read them.

A caller pulses `start_i` with the operand and a constant select. Entry 0 takes the operand, and the other entries clear. The block then steps through the selected program and raises `done_o` for one cycle after the last step. The product is read from entry 1, and it stays on `result_o` until the next accepted start. A select with no stored program completes at once, raises the unsupported flag and returns zero. The caller then falls back to a real multiply.

Top module: `cmul_seq`

## Requirements
- R1: While reset is asserted and after it is released with no start, `done_o`, `unsup_o` and `result_o` are all zero.
- R2: `const_sel_i` values 0, 1, 2, 3, 4 and 5 select the constants 10, 59, 7, 3, 100 and 45. On completion, `result_o` equals `operand_i` times that constant.
- R3: The programs for selects 0 to 5 take 2, 3, 2, 1, 3 and 2 steps, one step per clock edge after the accepting edge. `done_o` is high for exactly one cycle, the cycle after the edge that runs the last step.
- R4: A `const_sel_i` of 6 or 7 has no program. `done_o` and `unsup_o` are both high in the cycle after the accepting edge, and `result_o` is zero.
- R5: `unsup_o` stays low whenever a supported select completes.
- R6: A start is accepted only when no program is running. A start raised during a run changes neither that run's result nor its completion cycle, and it begins no second run.
- R7: After completion, `result_o` holds its value until the next accepted start. A start raised in the `done_o` cycle is accepted.
- R8: Products wrap modulo 2^32, and no flag or error signals the overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a multiply (ignored while busy) |
| operand_i | input | 32 | Integer multiplicand, sampled on the accepting edge |
| const_sel_i | input | 3 | Constant select, sampled on the accepting edge |
| result_o | output | 32 | Product, valid from `done_o` until the next accepted start |
| done_o | output | 1 | One-cycle completion pulse |
| unsup_o | output | 1 | High with `done_o` when the select has no program |

## Verification
A wrong step encoding, a wrong source index or a temporary that gets overwritten too early gives a wrong product on `result_o` in the `done_o` cycle. An off-by-one in the step counter or the last-step flag moves `done_o` by one or more cycles. The bench compares `done_o`, `unsup_o` and the held result against a behavioural model on every clock, so either fault shows up within one program length, at most four cycles after the start. Operands of zero, one, all-ones and the top bit alone drive the products into wraparound.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
  localparam int RF_DEPTH  = 4;
  localparam int RF_IDX_W  = $clog2(RF_DEPTH);
  localparam int SH_W      = 5;
  localparam int MAX_STEPS = 3;
  localparam int STEP_W    = $clog2(MAX_STEPS + 1);
  localparam int SEL_W     = 3;
  localparam int NUM_PROGS = 6;
  localparam int RES_IDX   = 1;

  typedef enum logic [2:0] {
    OP_ADD1 = 3'd0,
    OP_ADD2 = 3'd1,
    OP_ADD4 = 3'd2,
    OP_ADD8 = 3'd3,
    OP_SUB  = 3'd4,
    OP_SHL  = 3'd5
  } uop_e;

  typedef struct packed {
    uop_e                op;
    logic [RF_IDX_W-1:0] dst;
    logic [RF_IDX_W-1:0] src_a;
    logic [RF_IDX_W-1:0] src_b;
    logic [SH_W-1:0]     sh;
    logic                last;
  } uinst_t;

  function automatic uinst_t mk(uop_e op, int d, int a, int b, int sh, bit last);
    uinst_t u;
    u.op    = op;
    u.dst   = RF_IDX_W'(d);
    u.src_a = RF_IDX_W'(a);
    u.src_b = RF_IDX_W'(b);
    u.sh    = SH_W'(sh);
    u.last  = last;
    return u;
  endfunction
endpackage

// File: rtl/cmul_prog_rom.sv
module cmul_prog_rom
  import cmul_pkg::*;
(
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [STEP_W-1:0] step_i,
  output uinst_t            inst_o
);
  always_comb begin
    case ({sel_i, step_i})
      // x10: 5s, then doubled
      {3'd0, 2'd0}: inst_o = mk(OP_ADD4, 1, 0, 0, 0, 1'b0);
      {3'd0, 2'd1}: inst_o = mk(OP_ADD1, 1, 1, 1, 0, 1'b1);
      // x59: t=3s in entry 2, 7s, then 8*7s+t
      {3'd1, 2'd0}: inst_o = mk(OP_ADD2, 2, 0, 0, 0, 1'b0);
      {3'd1, 2'd1}: inst_o = mk(OP_ADD2, 1, 2, 0, 0, 1'b0);
      {3'd1, 2'd2}: inst_o = mk(OP_ADD8, 1, 1, 2, 0, 1'b1);
      // x7: 8s - s
      {3'd2, 2'd0}: inst_o = mk(OP_SHL,  1, 0, 0, 3, 1'b0);
      {3'd2, 2'd1}: inst_o = mk(OP_SUB,  1, 1, 0, 0, 1'b1);
      // x3
      {3'd3, 2'd0}: inst_o = mk(OP_ADD2, 1, 0, 0, 0, 1'b1);
      // x100: 5s, 25s, then <<2
      {3'd4, 2'd0}: inst_o = mk(OP_ADD4, 1, 0, 0, 0, 1'b0);
      {3'd4, 2'd1}: inst_o = mk(OP_ADD4, 1, 1, 1, 0, 1'b0);
      {3'd4, 2'd2}: inst_o = mk(OP_SHL,  1, 1, 0, 2, 1'b1);
      // x45: 9s, then 45s
      {3'd5, 2'd0}: inst_o = mk(OP_ADD8, 1, 0, 0, 0, 1'b0);
      {3'd5, 2'd1}: inst_o = mk(OP_ADD4, 1, 1, 1, 0, 1'b1);
      default:      inst_o = mk(OP_ADD1, 0, 0, 0, 0, 1'b1);
    endcase
  end
endmodule

// File: rtl/cmul_step_alu.sv
module cmul_step_alu
  import cmul_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  uop_e              op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [SH_W-1:0]   sh_i,
  output logic [DATA_W-1:0] y_o
);
  always_comb begin
    case (op_i)
      OP_ADD1: y_o = a_i + b_i;
      OP_ADD2: y_o = (a_i << 1) + b_i;
      OP_ADD4: y_o = (a_i << 2) + b_i;
      OP_ADD8: y_o = (a_i << 3) + b_i;
      OP_SUB:  y_o = a_i - b_i;
      OP_SHL:  y_o = a_i << sh_i;
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/cmul_rf.sv
module cmul_rf
  import cmul_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                init_i,
  input  logic [DATA_W-1:0]   init_val_i,
  input  logic                we_i,
  input  logic [RF_IDX_W-1:0] waddr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [RF_IDX_W-1:0] raddr_a_i,
  input  logic [RF_IDX_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0]   rdata_a_o,
  output logic [DATA_W-1:0]   rdata_b_o,
  output logic [DATA_W-1:0]   res_o
);
  logic [DATA_W-1:0] regs [RF_DEPTH];

  for (genvar g = 0; g < RF_DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 regs[g] <= '0;
      else if (init_i)                             regs[g] <= (g == 0) ? init_val_i : '0;
      else if (we_i && waddr_i == RF_IDX_W'(g))    regs[g] <= wdata_i;
    end
  end

  assign rdata_a_o = regs[raddr_a_i];
  assign rdata_b_o = regs[raddr_b_i];
  assign res_o     = regs[RES_IDX];
endmodule

// File: rtl/cmul_seq.sv
module cmul_seq
  import cmul_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic [SEL_W-1:0]  const_sel_i,
  output logic [DATA_W-1:0] result_o,
  output logic              done_o,
  output logic              unsup_o
);
  logic              busy_q, done_q, unsup_q;
  logic [STEP_W-1:0] step_q;
  logic [SEL_W-1:0]  sel_q;
  logic              accept, sel_ok;
  uinst_t            inst;
  logic [DATA_W-1:0] opa, opb, alu_y;

  assign accept = start_i && !busy_q;
  assign sel_ok = const_sel_i < SEL_W'(NUM_PROGS);

  cmul_prog_rom u_rom (
    .sel_i  (sel_q),
    .step_i (step_q),
    .inst_o (inst)
  );

  cmul_rf #(.DATA_W(DATA_W)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (accept),
    .init_val_i (operand_i),
    .we_i       (busy_q),
    .waddr_i    (inst.dst),
    .wdata_i    (alu_y),
    .raddr_a_i  (inst.src_a),
    .raddr_b_i  (inst.src_b),
    .rdata_a_o  (opa),
    .rdata_b_o  (opb),
    .res_o      (result_o)
  );

  cmul_step_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i (inst.op),
    .a_i  (opa),
    .b_i  (opb),
    .sh_i (inst.sh),
    .y_o  (alu_y)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      unsup_q <= 1'b0;
      step_q  <= '0;
      sel_q   <= '0;
    end else begin
      done_q  <= 1'b0;
      unsup_q <= 1'b0;
      if (accept) begin
        sel_q  <= const_sel_i;
        step_q <= '0;
        if (sel_ok) begin
          busy_q <= 1'b1;
        end else begin
          done_q  <= 1'b1;
          unsup_q <= 1'b1;
        end
      end else if (busy_q) begin
        step_q <= step_q + STEP_W'(1);
        if (inst.last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o  = done_q;
  assign unsup_o = unsup_q;

  // done is a single-cycle pulse unless an unsupported start re-fires it
  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !(start_i && !sel_ok)) |=> !done_o);

  assert_step_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> step_q < STEP_W'(MAX_STEPS));

  assert_unsup_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsup_o |-> (done_o && result_o == '0));

  assert_busy_ignores_start_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> ($stable(sel_q) && !unsup_o));

  assert_result_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !start_i) |=> $stable(result_o));
endmodule

// File: tb/cmul_seq_tb_top.sv
module cmul_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] operand = '0;
  logic [2:0]  sel = '0;
  logic [31:0] result;
  logic        done, unsup;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  cmul_seq dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .start_i     (start),
    .operand_i   (operand),
    .const_sel_i (sel),
    .result_o    (result),
    .done_o      (done),
    .unsup_o     (unsup)
  );

  function automatic logic [31:0] k_of(int s);
    case (s)
      0: return 32'd10;  1: return 32'd59;  2: return 32'd7;
      3: return 32'd3;   4: return 32'd100; 5: return 32'd45;
      default: return 32'd0;
    endcase
  endfunction

  function automatic int steps_of(int s);
    case (s)
      0: return 2; 1: return 3; 2: return 2; 3: return 1; 4: return 3; 5: return 2;
      default: return 0;
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int          m_cnt;
  logic        m_done, m_unsup, m_hold;
  logic [31:0] m_res;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_done <= 0; m_unsup <= 0; m_hold <= 0; m_res <= '0;
    end else begin
      m_done  <= 0;
      m_unsup <= 0;
      if (m_cnt > 0) begin
        m_cnt <= m_cnt - 1;
        if (m_cnt == 1) begin m_done <= 1; m_hold <= 1; end
      end else if (start) begin
        m_hold <= 0;
        if (sel < 3'd6) begin
          m_cnt <= steps_of(int'(sel));
          m_res <= operand * k_of(int'(sel));
        end else begin
          m_done <= 1; m_unsup <= 1; m_res <= '0; m_hold <= 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      check(done == m_done, "R3 done timing", 32'(done), 32'(m_done));
      check(unsup == m_unsup, "R4/R5 unsup flag", 32'(unsup), 32'(m_unsup));
      if (m_hold) check(result == m_res, "R2/R7 result", result, m_res);
    end
  end

  task automatic run(int s, logic [31:0] op, string req);
    int c;
    @(negedge clk);
    start = 1'b1; sel = 3'(s); operand = op;
    @(negedge clk);
    start = 1'b0;
    c = 1;
    while (!done && c < 20) begin @(negedge clk); c++; end
    check(c == ((s < 6) ? steps_of(s) + 1 : 1), "R3 latency", 32'(c),
          32'((s < 6) ? steps_of(s) + 1 : 1));
    check(result == op * k_of(s), req, result, op * k_of(s));
    check(unsup == (s >= 6), "R4/R5 flag at done", 32'(unsup), 32'(s >= 6));
    @(negedge clk);
    @(negedge clk);
    check(result == op * k_of(s), "R7 hold", result, op * k_of(s));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(done == 0 && unsup == 0 && result == 0, "R1 in reset", result, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 0 && unsup == 0 && result == 0, "R1 after reset", result, 32'd0);

    for (int s = 0; s < 6; s++) begin
      run(s, 32'd0, "R2 zero");
      run(s, 32'd1, "R2 one");
      run(s, 32'hFFFF_FFFF, "R8 wrap all-ones");
      run(s, 32'h8000_0000, "R8 wrap top bit");
      for (int i = 0; i < 6; i++) run(s, $urandom, "R2 random");
    end
    run(6, 32'h1234_5678, "R4 sel6 zero");
    run(7, 32'hDEAD_BEEF, "R4 sel7 zero");
    run(1, 32'd1000, "R2 x59 temp reuse");

    // R6: start held high through a x10 run with different inputs
    @(negedge clk);
    start = 1'b1; sel = 3'd0; operand = 32'd77;
    @(negedge clk);
    sel = 3'd1; operand = 32'd5;
    @(negedge clk);
    check(done == 0, "R6 no early done", 32'(done), 32'd0);
    @(negedge clk);
    start = 1'b0;
    check(done == 1 && result == 32'd770, "R6 run unaffected", result, 32'd770);
    @(negedge clk);
    check(done == 0 && result == 32'd770, "R6 no second run", result, 32'd770);

    // R7: start in the done cycle is accepted
    @(negedge clk);
    start = 1'b1; sel = 3'd2; operand = 32'd9;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk); @(negedge clk);
    check(done == 1 && result == 32'd63, "R7 first of pair", result, 32'd63);
    start = 1'b1; sel = 3'd3; operand = 32'd11;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(done == 1 && result == 32'd33, "R7 back-to-back accepted", result, 32'd33);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule